// File: doc/BRIEF.md
# E1 CRC-4 Submultiframe Generator and Checker

This block produces and verifies the four CRC-4 check bits of an E1 submultiframe. It sits behind a framer that has already found alignment and that presents the 2.048 Mbit/s stream one bit at a time. A bit strobe marks each valid bit, together with the multiframe frame number (0 to 15) and the bit position inside the frame (0 to 255). A submultiframe is eight frames, either frames 0 to 7 or frames 8 to 15. Its check block is therefore 2048 bits long.

On the transmit side, the remainder computed over one submultiframe is held and written into the check-bit slots of the next submultiframe. Every other bit passes through unchanged. On the receive side, the remainder of each submultiframe is held and compared with the check bits that arrive in the following submultiframe. A one-clock error pulse flags a mismatch. An alignment controller can hold off this pulse through a disable input.

Top module: `crc4_smf_engine`

## Requirements
- R1: Each submultiframe is divided by x^4 + x + 1 with its first bit as the most significant coefficient. The first bit is bit position 0 of frame 0 or frame 8, and the last is bit position 255 of frame 7 or frame 15. The divider starts from zero at the first bit.
- R2: The check-bit slots are bit position 0 of relative frames 0, 2, 4 and 6 (frame_num modulo 8), carrying C1, C2, C3 and C4 in that order. Both directions enter these slots into the division as 0, whatever their input value.
- R3: In each check-bit slot, tx_dout carries the remainder of the previous submultiframe, with C1 as the most significant remainder bit.
- R4: In every position other than a check-bit slot, tx_dout equals tx_din.
- R5: If any received check bit differs from the remainder of the previous received submultiframe, rx_crc_err is high during the clock cycle that follows the C4 bit strobe. If all four match, rx_crc_err stays low.
- R6: If chk_disable is high at the C4 bit strobe, no error pulse is produced.
- R7: After reset, the held remainders are zero, so the transmit side inserts zeros. No receive comparison is reported until a full submultiframe end has been seen.
- R8: While bit_en is low, no state advances and no error pulse is started.
- R9: rx_crc_err is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Strobe marking a valid stream bit |
| frame_num | input | 4 | Frame number within the multiframe, 0 to 15 |
| bit_pos | input | 8 | Bit position within the frame, 0 to 255 |
| tx_din | input | 1 | Transmit data bit before check-bit insertion |
| rx_din | input | 1 | Received data bit |
| chk_disable | input | 1 | Suppresses the receive error pulse |
| tx_dout | output | 1 | Transmit data bit with check bits inserted |
| rx_crc_err | output | 1 | One-cycle receive CRC-4 mismatch pulse |

## Verification
At the first bit of every submultiframe, the C1 slot is used in three ways at once. The divider restarts and takes the slot as a forced zero. The receive side compares the incoming C1 against the stored remainder. The transmit side overwrites the same slot. The bench provokes this by driving ones in the check-bit slots of the data patterns and by flipping C1 in the receive stream. It expects an error from the flipped C1, and it expects correct remainders in later submultiframes despite the ones in those slots. Other vectors insert idle strobes and place a submultiframe end just before a disabled or corrupted comparison.

// File: rtl/crc4_pkg.sv
package crc4_pkg;

   // position flags decoded from frame number and bit position
   typedef struct packed {
      logic sof;    // first bit of a submultiframe
      logic eof;    // last bit of a submultiframe
      logic cbit;   // one of the check-bit slots
      logic clast;  // the final check-bit slot (C4)
   } slot_t;

endpackage

// File: rtl/crc4_slot_decode.sv
module crc4_slot_decode
   import crc4_pkg::*;
#(
   parameter int FRAME_BITS = 256,
   parameter int SMF_FRAMES = 8,
   parameter int CRC_W      = 4,
   localparam int BP_W = $clog2(FRAME_BITS),
   localparam int RF_W = $clog2(SMF_FRAMES),
   localparam int FN_W = RF_W + 1,
   localparam int CI_W = RF_W - 1
) (
   input  logic [FN_W-1:0] frame_num,
   input  logic [BP_W-1:0] bit_pos,
   output slot_t           slot,
   output logic [CI_W-1:0] cidx
);

   logic [RF_W-1:0] rel;
   logic            first_bit;
   logic            unused_half;

   assign rel         = frame_num[RF_W-1:0];
   assign unused_half = frame_num[FN_W-1];
   assign first_bit   = (bit_pos == '0);
   assign cidx        = rel[RF_W-1:1];

   always_comb begin
      slot.sof   = first_bit && (rel == '0);
      slot.eof   = (int'(bit_pos) == FRAME_BITS - 1) && (int'(rel) == SMF_FRAMES - 1);
      slot.cbit  = first_bit && !rel[0] && (int'(cidx) < CRC_W);
      slot.clast = slot.cbit && (int'(cidx) == CRC_W - 1);
   end

endmodule

// File: rtl/crc4_lfsr.sv
module crc4_lfsr #(
   parameter int           W    = 4,
   parameter logic [W-1:0] POLY = 4'b0011
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         clr,
   input  logic         din,
   output logic [W-1:0] nxt
);

   logic [W-1:0] q;
   logic [W-1:0] base;
   logic         fb;

   assign base = clr ? '0 : q;
   assign fb   = din ^ base[W-1];

   for (genvar i = 0; i < W; i++) begin : g_tap
      if (i == 0) begin : g_lsb
         assign nxt[i] = POLY[i] & fb;
      end else begin : g_up
         assign nxt[i] = base[i-1] ^ (POLY[i] & fb);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= nxt;
   end

endmodule

// File: rtl/crc4_rx_check.sv
module crc4_rx_check
   import crc4_pkg::*;
#(
   parameter int CRC_W = 4,
   parameter int CI_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  slot_t            slot,
   input  logic [CI_W-1:0]  cidx,
   input  logic             rx_din,
   input  logic [CRC_W-1:0] new_rem,
   input  logic             chk_disable,
   output logic             err
);

   logic [CRC_W-1:0] rx_ref_q;
   logic             valid_q;
   logic             acc_q;
   logic             miss;

   assign miss = rx_din ^ rx_ref_q[CRC_W-1-int'(cidx)];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_ref_q <= '0;
         valid_q  <= 1'b0;
         acc_q    <= 1'b0;
         err      <= 1'b0;
      end else begin
         err <= 1'b0;
         if (en) begin
            if (slot.clast) begin
               err   <= valid_q && !chk_disable && (acc_q || miss);
               acc_q <= 1'b0;
            end else if (slot.cbit) begin
               acc_q <= acc_q || miss;
            end
            if (slot.eof) begin
               rx_ref_q <= new_rem;
               valid_q  <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/crc4_smf_engine.sv
module crc4_smf_engine
   import crc4_pkg::*;
#(
   parameter int               FRAME_BITS = 256,
   parameter int               SMF_FRAMES = 8,
   parameter int               CRC_W      = 4,
   parameter logic [CRC_W-1:0] POLY       = 4'b0011,
   parameter bit               REG_TXOUT  = 1'b0,
   localparam int BP_W = $clog2(FRAME_BITS),
   localparam int RF_W = $clog2(SMF_FRAMES),
   localparam int FN_W = RF_W + 1,
   localparam int CI_W = RF_W - 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bit_en,
   input  logic [FN_W-1:0] frame_num,
   input  logic [BP_W-1:0] bit_pos,
   input  logic            tx_din,
   input  logic            rx_din,
   input  logic            chk_disable,
   output logic            tx_dout,
   output logic            rx_crc_err
);

   // elaboration-time parameter checks
   if ((1 << RF_W) != SMF_FRAMES) begin : g_bad_frames
      $error("SMF_FRAMES must be a power of two");
   end
   if ((1 << BP_W) != FRAME_BITS) begin : g_bad_bits
      $error("FRAME_BITS must be a power of two");
   end
   if (SMF_FRAMES < 2 * CRC_W) begin : g_bad_slots
      $error("not enough even frames to carry all check bits");
   end
   if (!POLY[0]) begin : g_bad_poly
      $error("generator polynomial needs a constant term");
   end

   slot_t            slot;
   logic [CI_W-1:0]  cidx;
   logic [CRC_W-1:0] tx_nxt;
   logic [CRC_W-1:0] rx_nxt;
   logic [CRC_W-1:0] tx_hold_q;
   logic             tx_mux;

   crc4_slot_decode #(
      .FRAME_BITS(FRAME_BITS), .SMF_FRAMES(SMF_FRAMES), .CRC_W(CRC_W)
   ) u_dec (
      .frame_num(frame_num), .bit_pos(bit_pos), .slot(slot), .cidx(cidx)
   );

   crc4_lfsr #(.W(CRC_W), .POLY(POLY)) u_tx_div (
      .clk(clk), .rst_n(rst_n), .en(bit_en), .clr(slot.sof),
      .din(tx_din && !slot.cbit), .nxt(tx_nxt)
   );

   crc4_lfsr #(.W(CRC_W), .POLY(POLY)) u_rx_div (
      .clk(clk), .rst_n(rst_n), .en(bit_en), .clr(slot.sof),
      .din(rx_din && !slot.cbit), .nxt(rx_nxt)
   );

   crc4_rx_check #(.CRC_W(CRC_W), .CI_W(CI_W)) u_chk (
      .clk(clk), .rst_n(rst_n), .en(bit_en), .slot(slot), .cidx(cidx),
      .rx_din(rx_din), .new_rem(rx_nxt), .chk_disable(chk_disable),
      .err(rx_crc_err)
   );

   // transmit remainder, carried into the next submultiframe
   always_ff @(posedge clk) begin
      if (!rst_n)                tx_hold_q <= '0;
      else if (bit_en && slot.eof) tx_hold_q <= tx_nxt;
   end

   assign tx_mux = slot.cbit ? tx_hold_q[CRC_W-1-int'(cidx)] : tx_din;

   if (REG_TXOUT) begin : g_tx_reg
      always_ff @(posedge clk) begin
         if (!rst_n)      tx_dout <= 1'b0;
         else if (bit_en) tx_dout <= tx_mux;
      end
   end else begin : g_tx_comb
      assign tx_dout = tx_mux;
   end

endmodule

// File: rtl/crc4_smf_sva.sv
module crc4_smf_sva #(
   parameter int               FRAME_BITS = 256,
   parameter int               SMF_FRAMES = 8,
   parameter int               CRC_W      = 4,
   parameter logic [CRC_W-1:0] POLY       = 4'b0011,
   parameter bit               REG_TXOUT  = 1'b0,
   localparam int BP_W = $clog2(FRAME_BITS),
   localparam int RF_W = $clog2(SMF_FRAMES),
   localparam int FN_W = RF_W + 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bit_en,
   input logic [FN_W-1:0] frame_num,
   input logic [BP_W-1:0] bit_pos,
   input logic            tx_din,
   input logic            rx_din,
   input logic            chk_disable,
   input logic            tx_dout,
   input logic            rx_crc_err
);

   logic unused_sva;
   logic at_c4;
   logic at_end;
   logic at_slot;
   logic seen_end_q;
   int   relf;

   assign unused_sva = rx_din ^ frame_num[FN_W-1] ^ POLY[0];
   assign relf    = int'(frame_num[RF_W-1:0]);
   assign at_slot = (bit_pos == '0) && (relf % 2 == 0) && (relf < 2 * CRC_W);
   assign at_c4   = bit_en && (bit_pos == '0) && (relf == 2 * (CRC_W - 1));
   assign at_end  = bit_en && (int'(bit_pos) == FRAME_BITS - 1) && (relf == SMF_FRAMES - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)      seen_end_q <= 1'b0;
      else if (at_end) seen_end_q <= 1'b1;
   end

   a_r5_err_follows_c4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_crc_err |-> $past(at_c4));

   a_r6_disable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      rx_crc_err |-> !$past(chk_disable));

   a_r7_first_skipped: assert property (@(posedge clk) disable iff (!rst_n)
      rx_crc_err |-> seen_end_q);

   a_r8_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> !rx_crc_err);

   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_crc_err |=> !rx_crc_err);

   a_r4_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (!REG_TXOUT && !at_slot) |-> (tx_dout == tx_din));

endmodule

bind crc4_smf_engine crc4_smf_sva #(
   .FRAME_BITS(FRAME_BITS), .SMF_FRAMES(SMF_FRAMES), .CRC_W(CRC_W),
   .POLY(POLY), .REG_TXOUT(REG_TXOUT)
) u_sva (.*);

// File: tb/tb_crc4_smf_engine.sv
`timescale 1ns/1ps
module tb_crc4_smf_engine;

   typedef struct packed {
      logic [1:0]  pat;     // 0 zeros, 1 ones, 2 prbs, 3 alternating
      logic [15:0] seed;
      logic [3:0]  corrupt; // bit 3 flips C1 ... bit 0 flips C4
      logic        dis;
      logic        gap;     // idle cycle after every bit
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{2'd2, 16'hACE1, 4'b0000, 1'b0, 1'b0},
      '{2'd1, 16'h0000, 4'b0000, 1'b0, 1'b0},
      '{2'd2, 16'h1234, 4'b1000, 1'b0, 1'b0},
      '{2'd3, 16'h0000, 4'b0001, 1'b0, 1'b0},
      '{2'd0, 16'h0000, 4'b0110, 1'b1, 1'b0},
      '{2'd2, 16'hBEEF, 4'b0000, 1'b0, 1'b1},
      '{2'd2, 16'h0F0F, 4'b1111, 1'b0, 1'b1},
      '{2'd1, 16'h0000, 4'b0010, 1'b0, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic [3:0] frame_num = '0;
   logic [7:0] bit_pos = '0;
   logic       tx_din = 1'b0;
   logic       rx_din = 1'b0;
   logic       chk_disable = 1'b0;
   logic       tx_dout;
   logic       rx_crc_err;

   crc4_smf_engine dut (.*);

   always #4 clk = ~clk;

   int   n_chk = 0;
   int   n_fail = 0;
   logic dat [2048];
   logic [3:0] tx_prev = '0;
   logic [3:0] rx_prev = '0;
   bit   rx_valid = 0;
   bit   half = 0;
   bit   pend = 0;
   bit   pend_exp = 0;
   int   stray = 0;
   string pend_tag;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // reference remainder: long division of the block times x^4, slots zeroed
   function automatic logic [3:0] ref_crc();
      logic [4:0] r = '0;
      for (int i = 0; i < 2052; i++) begin
         logic b;
         b = (i < 2048) ? (dat[i] && !((i % 256 == 0) && ((i / 256) % 2 == 0))) : 1'b0;
         r = {r[3:0], b};
         if (r[4]) r = r ^ 5'b10011;
      end
      return r[3:0];
   endfunction

   task automatic sample_err();
      if (pend) begin
         check(rx_crc_err == pend_exp, pend_tag, rx_crc_err, pend_exp);
         pend = 0;
      end else if (rx_crc_err) begin
         stray++;
      end
   endtask

   task automatic run_smf(input vec_t v, input string tag);
      logic [15:0] s = v.seed;
      logic [3:0]  rem;
      int pass_bad = 0;
      bit exp_err;
      stray = 0;
      for (int i = 0; i < 2048; i++) begin
         case (v.pat)
            2'd0: dat[i] = 1'b0;
            2'd1: dat[i] = 1'b1;
            2'd2: begin dat[i] = s[0]; s = (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0); end
            default: dat[i] = i[0];
         endcase
      end
      rem = ref_crc();
      exp_err = rx_valid && (v.corrupt != 4'b0) && !v.dis;
      for (int i = 0; i < 2048; i++) begin
         bit cb;
         int ci;
         cb = (i % 256 == 0) && ((i / 256) % 2 == 0);
         ci = i / 512;
         @(negedge clk);
         sample_err();
         bit_en      = 1'b1;
         frame_num   = 4'(half * 8 + i / 256);
         bit_pos     = 8'(i % 256);
         tx_din      = dat[i];
         rx_din      = cb ? (rx_prev[3-ci] ^ v.corrupt[3-ci]) : dat[i];
         chk_disable = v.dis;
         #1;
         if (cb) begin
            check(tx_dout == tx_prev[3-ci], {tag, " R3/R1/R2 tx check bit"}, tx_dout, tx_prev[3-ci]);
         end else if (tx_dout != tx_din) begin
            pass_bad++;
         end
         if (cb && ci == 3) begin
            pend = 1; pend_exp = exp_err;
            pend_tag = {tag, " R5/R6 rx error pulse"};
         end
         if (v.gap) begin
            @(negedge clk);
            sample_err();
            bit_en    = 1'b0;
            frame_num = 4'(i % 16);
            bit_pos   = 8'd0;
            tx_din    = 1'b1;
            rx_din    = ~rx_din;
         end
      end
      check(pass_bad == 0, {tag, " R4 passthrough mismatches"}, pass_bad, 0);
      tx_prev = rem; rx_prev = rem; rx_valid = 1; half = ~half;
      @(negedge clk);
      sample_err();
      bit_en = 1'b0;
      check(stray == 0, {tag, " R9/R8 stray error pulses"}, stray, 0);
   endtask

   initial begin
      #(200000 * 8);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // reset state: slot C1 inserts zero, no error pulse (R7)
      rst_n = 1'b0; frame_num = 4'd0; bit_pos = 8'd0; tx_din = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      check(tx_dout == 1'b0, "R7 reset tx slot value", tx_dout, 0);
      check(rx_crc_err == 1'b0, "R7 reset error output", rx_crc_err, 0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         run_smf(VEC[k], $sformatf("vec%0d", k));
      end

      // reset mid-stream: held remainders cleared, first comparison skipped (R7)
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      tx_prev = '0; rx_prev = '0; rx_valid = 0; half = 0;
      run_smf('{2'd2, 16'h5A5A, 4'b1111, 1'b0, 1'b0}, "R7 after reset");
      run_smf('{2'd2, 16'h3C3C, 4'b0100, 1'b0, 1'b0}, "R7 second smf");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule